// File: doc/BRIEF.md
# Signaling-NaN Classifier and Quieter

This block inspects one single-precision floating-point word per accepted strobe. It reports whether the word is a NaN and whether that NaN is signaling, and for a signaling NaN it returns the quieted NaN together with an invalid-operation flag. Any other word comes back unchanged with the flag low. Arithmetic and the choice between two NaN operands belong to the surrounding datapath.

A mode input selects the convention that defines the quiet indicator, which is the top fraction bit (bit 22). With `mode_2008` high, a clear bit 22 marks a signaling NaN and quieting sets that bit. With `mode_2008` low (the legacy convention), a set bit 22 marks a signaling NaN and quieting clears it. Clearing bit 22 alone would turn a NaN with an otherwise-zero fraction into an infinity, so in that case bit 21 is set as well.

The result is registered one cycle after `in_valid`. A two-state controller tracks whether an output is on the bus. `OUT_IDLE` means no result is presented. `OUT_LIVE` means `out_valid` is high and the flags are meaningful. The transitions are: IDLE to LIVE on `in_valid`; LIVE stays LIVE while `in_valid` stays high; LIVE returns to IDLE when a cycle has no `in_valid`; IDLE stays IDLE otherwise. The result word holds its last value between strobes.

Top module: `snan_quiet_unit`

## Requirements
- R1: `out_is_nan` is 1 exactly when the exponent field (bits 30:23) is all ones and the fraction (bits 22:0) is nonzero. An infinity (fraction zero) is not a NaN.
- R2: `out_is_snan` is 1 exactly for a NaN whose bit 22 XOR `mode_2008` equals 1. With `mode_2008`=1, bit 22 = 0 is signaling. With `mode_2008`=0, bit 22 = 1 is signaling.
- R3: `out_invalid` is 1 exactly when the presented word was a signaling NaN.
- R4: With `mode_2008`=1, a signaling NaN is returned with bit 22 set and every other bit unchanged.
- R5: With `mode_2008`=0, a signaling NaN whose bits 21:0 are nonzero is returned with bit 22 cleared and every other bit unchanged.
- R6: With `mode_2008`=0, a signaling NaN whose bits 21:0 are all zero is returned with bit 22 cleared and bit 21 set, so the result stays a NaN.
- R7: A word that is not a signaling NaN, including quiet NaNs, infinities, zeros and ordinary numbers, is returned bit-for-bit unchanged with `out_invalid`=0.
- R8: Sign (bit 31) and exponent (bits 30:23) of the result always equal those of the input.
- R9: `out_valid` rises in the cycle after `in_valid` and is low otherwise. `out_is_nan`, `out_is_snan` and `out_invalid` are 0 whenever `out_valid` is 0.
- R10: While `rst_n` is low, `out_valid`, all flags and `out_word` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is presented this cycle |
| in_word | input | 32 | Single-precision operand |
| mode_2008 | input | 1 | 1 = 2008 NaN convention, 0 = legacy convention |
| out_valid | output | 1 | Result registered from last cycle's input |
| out_is_nan | output | 1 | Operand was a NaN |
| out_is_snan | output | 1 | Operand was a signaling NaN |
| out_word | output | 32 | Quieted NaN or unchanged operand |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
The bench targets the legacy NaN whose fraction is only bit 22. A design that merely cleared the bit would return an infinity, and one that set bit 21 unconditionally would corrupt NaN payloads. It feeds the same words under both conventions, because swapping the XOR polarity flags quiet NaNs and lets signaling ones through. It also sends infinities with either sign and words that differ from a NaN by one exponent bit, to catch a detector that looks only at the fraction or only at the exponent. Gaps in `in_valid` show whether flags leak while `out_valid` is low, and back-to-back strobes show whether the controller drops a result.

// File: rtl/snq_pkg.sv
package snq_pkg;
    localparam int SNQ_EXP_W  = 8;
    localparam int SNQ_FRAC_W = 23;

    typedef enum logic {
        OUT_IDLE = 1'b0,
        OUT_LIVE = 1'b1
    } snq_out_state_e;
endpackage

// File: rtl/snq_classify.sv
module snq_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    input  logic                  mode_2008,
    output logic                  is_nan,
    output logic                  is_snan
);
    logic exp_full;
    logic frac_nz;
    logic qbit;

    always_comb begin
        exp_full = &word[FRAC_W +: EXP_W];
        frac_nz  = |word[FRAC_W-1:0];
        qbit     = word[FRAC_W-1];
        is_nan   = exp_full & frac_nz;
        is_snan  = is_nan & (qbit ^ mode_2008);
    end
endmodule

// File: rtl/snq_quieter.sv
module snq_quieter #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    input  logic                  mode_2008,
    output logic [EXP_W+FRAC_W:0] quiet_word
);
    localparam int QPOS = FRAC_W - 1;
    localparam int NPOS = FRAC_W - 2;

    logic low_zero;

    always_comb begin
        low_zero   = ~|word[NPOS:0];
        quiet_word = word;
        if (mode_2008) begin
            quiet_word[QPOS] = 1'b1;
        end else begin
            quiet_word[QPOS] = 1'b0;
            if (low_zero) begin
                quiet_word[NPOS] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/snan_quiet_unit.sv
module snan_quiet_unit #(
    parameter int EXP_W  = snq_pkg::SNQ_EXP_W,
    parameter int FRAC_W = snq_pkg::SNQ_FRAC_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [EXP_W+FRAC_W:0] in_word,
    input  logic                  mode_2008,
    output logic                  out_valid,
    output logic                  out_is_nan,
    output logic                  out_is_snan,
    output logic [EXP_W+FRAC_W:0] out_word,
    output logic                  out_invalid
);
    import snq_pkg::*;

    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int QPOS   = FRAC_W - 1;

    snq_out_state_e     state_q, state_d;
    logic               c_nan, c_snan;
    logic [WORD_W-1:0]  q_word, res_word;

    snq_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
        .word      (in_word),
        .mode_2008 (mode_2008),
        .is_nan    (c_nan),
        .is_snan   (c_snan)
    );

    snq_quieter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quieter (
        .word       (in_word),
        .mode_2008  (mode_2008),
        .quiet_word (q_word)
    );

    always_comb begin
        res_word = c_snan ? q_word : in_word;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE: state_d = in_valid ? OUT_LIVE : OUT_IDLE;
            OUT_LIVE: state_d = in_valid ? OUT_LIVE : OUT_IDLE;
            default:  state_d = OUT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OUT_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_is_nan  <= 1'b0;
            out_is_snan <= 1'b0;
            out_invalid <= 1'b0;
            out_word    <= '0;
        end else begin
            out_is_nan  <= in_valid & c_nan;
            out_is_snan <= in_valid & c_snan;
            out_invalid <= in_valid & c_snan;
            if (in_valid) out_word <= res_word;
        end
    end

    always_comb begin
        out_valid = (state_q == OUT_LIVE);
    end

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R9
    flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_is_nan | out_is_snan | out_invalid));

    // R3
    invalid_needs_snan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> (out_is_snan && out_is_nan));

    // R8
    sign_exp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_word[WORD_W-1:FRAC_W] == $past(in_word[WORD_W-1:FRAC_W]));

    // R7
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_invalid) |-> out_word == $past(in_word));

    // R4
    quiet_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> out_word[QPOS] == $past(mode_2008));

    // R6
    stays_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> ((&out_word[WORD_W-2:FRAC_W]) && (|out_word[FRAC_W-1:0])));
endmodule

// File: tb/snan_quiet_unit_tb.sv
module snan_quiet_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = 32'h0;
    logic        mode_2008 = 1'b0;
    logic        out_valid, out_is_nan, out_is_snan, out_invalid;
    logic [31:0] out_word;

    int checks = 0;
    int fails  = 0;

    logic        e_valid = 1'b0, e_nan = 1'b0, e_snan = 1'b0, e_inv = 1'b0;
    logic [31:0] e_word = 32'h0;
    string       e_tag = "R10";

    always #5 clk = ~clk;

    snan_quiet_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .mode_2008(mode_2008), .out_valid(out_valid), .out_is_nan(out_is_nan),
        .out_is_snan(out_is_snan), .out_word(out_word), .out_invalid(out_invalid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R9 valid", {31'h0, out_valid}, {31'h0, e_valid});
        chk("R1 is_nan", {31'h0, out_is_nan}, {31'h0, e_nan});
        chk("R2 is_snan", {31'h0, out_is_snan}, {31'h0, e_snan});
        chk("R3 invalid", {31'h0, out_invalid}, {31'h0, e_inv});
        chk({e_tag, " word"}, out_word, e_word);
        chk("R8 sign/exp", {23'h0, out_word[31:23]}, {23'h0, e_word[31:23]});
    endtask

    // One cycle: check last result, then drive a new input and predict
    task automatic step(input logic v, input logic [31:0] w, input logic m);
        bit nan, sn;
        @(negedge clk);
        compare_all();
        in_valid  = v;
        in_word   = w;
        mode_2008 = m;
        nan = (w[30:23] == 8'hFF) && (w[22:0] != 0);
        sn  = nan && ((w[22] ^ m) == 1'b1);
        e_valid = v;
        e_nan   = v & nan;
        e_snan  = v & sn;
        e_inv   = v & sn;
        if (v) begin
            if (!sn) begin
                e_word = w;
                e_tag  = "R7";
            end else if (m) begin
                e_word = w | 32'h0040_0000;
                e_tag  = "R4";
            end else if (w[21:0] == 0) begin
                e_word = (w & ~32'h0040_0000) | 32'h0020_0000;
                e_tag  = "R6";
            end else begin
                e_word = w & ~32'h0040_0000;
                e_tag  = "R5";
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 valid", {31'h0, out_valid}, 32'h0);
        chk("R10 flags", {29'h0, out_is_nan, out_is_snan, out_invalid}, 32'h0);
        chk("R10 word", out_word, 32'h0);
        rst_n = 1'b1;
        // 2008 convention
        step(1, 32'h7F80_0001, 1);  // sNaN -> 7FC00001 (R4)
        step(1, 32'hFF80_1234, 1);  // negative sNaN
        step(1, 32'h7FC0_0000, 1);  // qNaN passes (R7)
        step(1, 32'h7F80_0000, 1);  // +inf (R1)
        step(0, 32'h7F80_0001, 1);  // gap (R9)
        step(1, 32'hFF80_0000, 1);  // -inf
        // legacy convention
        step(1, 32'h7FC0_0000, 0);  // sNaN, low zero -> 7FA00000 (R6)
        step(1, 32'hFFC0_0001, 0);  // sNaN -> FF800001 (R5)
        step(1, 32'h7F80_0001, 0);  // qNaN passes
        step(1, 32'h7FFF_FFFF, 0);  // sNaN all ones
        step(0, 32'h0000_0000, 0);
        step(0, 32'h7FC0_0000, 0);
        step(1, 32'h7F40_0001, 0);  // exponent one bit short
        step(1, 32'h3F80_0000, 1);  // 1.0
        step(1, 32'h0000_0000, 0);  // zero
        step(1, 32'h8000_0001, 1);  // denormal
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            w = $urandom;
            if (i % 2 == 0) w[30:23] = 8'hFF;
            if (i % 7 == 0) w[21:0] = 22'h0;
            step(($urandom % 4) != 0, w, $urandom % 2);
        end
        step(0, 32'h0, 0);
        step(0, 32'h0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule